// File: doc/BRIEF.md
# Constant-Coefficient Shift-Add Multiplier

This block multiplies a signed two's-complement sample by an unsigned constant that is fixed when the design is elaborated. It contains no hardware multiplier. Instead it builds one shifted copy of the sample for each term of the constant and sums those copies in a binary adder tree. At elaboration it counts the set bits of the constant and picks one of two recodings. The plain recoding adds one shifted copy for every set bit. The inverted recoding uses `b = 2^(S+1) - 1 - ~b`, which gives `(a << (S+1)) - a` minus one shifted copy for every clear bit. Whichever recoding needs fewer adders is kept, and a tie keeps the plain one. As a result, no constant of S+1 bits ever costs more than S+1 adders.

Samples enter and leave on valid/ready streams. An input is accepted on a rising edge when `in_valid` and `in_ready` are both high. An output is consumed on a rising edge when `out_valid` and `out_ready` are both high. The pipeline either advances as a whole or stalls as a whole. While `out_valid` is high and `out_ready` is low, every stage holds, `out_data` stays frozen and `in_ready` is low. `in_ready` is high whenever the output slot is empty or is being consumed in that cycle. Registers between the levels of the adder tree are optional and are selected by a parameter. Any sign of the coefficient is applied outside this block.

Top module: `cmul_shiftadd`

## Requirements
- R1: `out_data` equals the exact signed product `in_data * COEF`. `in_data` is IN_W-bit two's complement and COEF is unsigned S+1 bits. `out_data` is IN_W+S+1 bits wide, two's complement, and never wraps.
- R2: A constant with many set bits is built through the inverted recoding, and its product is still exact. This applies in particular to the all-ones constant.
- R3: With COEF = 0, every output is 0 for every input.
- R4: With COEF a single power of two 2^k, the output is the sign-extended input shifted left by k, and it appears one cycle after acceptance, whatever the pipelining setting.
- R5: A sample accepted at a rising edge appears on `out_valid`/`out_data` LAT edges later when there is no stall. LAT = 1 + (PIPE ? ceil(log2(T)) : 0), where T is the number of terms of the chosen recoding. For COEF = 8'hE9 (T = 5) with PIPE = 1, LAT is 4. For 8'hFF (T = 2), LAT is 2.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value.
- R7: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. So a stalled output blocks new input, and a free output slot admits it.
- R8: While `rst_n` is low, `out_valid` is 0 after the next edge. A sample in flight when reset is applied never appears.
- R9: The extreme inputs -2^(IN_W-1) and 2^(IN_W-1)-1 give exact products with the all-ones constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W | Signed multiplicand |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_data | output | IN_W+S+1 | Signed product |

## Verification
Two things can fall in the same cycle: a stall of the output and a new sample arriving at the input. The bench holds `out_ready` low while a sample makes its way through the pipeline. It then checks that the product waits at the output unchanged, that `in_ready` stays low, and that releasing `out_ready` drains the product exactly once. A reset that lands while a sample is still inside the tree is judged by that sample never surfacing. Every 8-bit input is swept through five constants at once: a mixed pattern with and without tree registers, all-ones, zero, and a single power of two. Each result is compared against the arithmetic product and against the latency predicted from the term count.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Number of set bits among the low n bits of v.
  function automatic int popcnt(input logic [63:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) c += int'(v[i]);
    return c;
  endfunction

  // Inverted recoding is kept only when it needs strictly fewer adders.
  // Plain recoding needs w-1 adders; inverted recoding needs s-w+2.
  function automatic bit use_inv(input logic [63:0] coef, input int s);
    int w;
    w = popcnt(coef, s + 1);
    return (s - w + 2) < (w - 1);
  endfunction

  // Number of terms fed to the adder tree (at least one).
  function automatic int n_terms(input logic [63:0] coef, input int s);
    int w;
    w = popcnt(coef, s + 1);
    if (use_inv(coef, s)) return (s + 1 - w) + 2;
    return (w == 0) ? 1 : w;
  endfunction

  // Left shift applied to term k.
  function automatic int term_shift(input logic [63:0] coef, input int s, input int k);
    int seen;
    seen = 0;
    if (use_inv(coef, s)) begin
      if (k == 0) return s + 1;
      if (k == 1) return 0;
      for (int i = 0; i <= s; i++) begin
        if (!coef[i]) begin
          if (seen == k - 2) return i;
          seen++;
        end
      end
    end else begin
      for (int i = 0; i <= s; i++) begin
        if (coef[i]) begin
          if (seen == k) return i;
          seen++;
        end
      end
    end
    return 0;
  endfunction

  // Term k is subtracted rather than added.
  function automatic bit term_neg(input logic [63:0] coef, input int s, input int k);
    return use_inv(coef, s) && (k != 0);
  endfunction

  // The constant is zero: the single term is a literal zero.
  function automatic bit term_null(input logic [63:0] coef, input int s);
    return popcnt(coef, s + 1) == 0;
  endfunction

endpackage

// File: rtl/cmul_terms.sv
module cmul_terms #(
  parameter int          IN_W = 8,
  parameter int          S    = 7,
  parameter logic [S:0]  COEF = '0,
  parameter int          NP   = 1,
  localparam int         PW   = IN_W + S + 1
) (
  input  logic signed [IN_W-1:0] a,
  output logic [NP*PW-1:0]       bus
);
  localparam int NT = cmul_pkg::n_terms(64'(COEF), S);

  logic signed [PW-1:0] ax;
  assign ax = PW'(a);

  for (genvar k = 0; k < NP; k++) begin : g_term
    if (k < NT && !cmul_pkg::term_null(64'(COEF), S)) begin : g_live
      localparam int SH  = cmul_pkg::term_shift(64'(COEF), S, k);
      localparam bit NEG = cmul_pkg::term_neg(64'(COEF), S, k);
      if (NEG) begin : g_sub
        assign bus[k*PW +: PW] = -(ax <<< SH);
      end else begin : g_add
        assign bus[k*PW +: PW] = ax <<< SH;
      end
    end else begin : g_pad
      assign bus[k*PW +: PW] = '0;
    end
  end
endmodule

// File: rtl/cmul_tree.sv
module cmul_tree #(
  parameter int PW   = 16,
  parameter int L    = 0,
  parameter int NP   = 1,
  parameter bit PIPE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [NP*PW-1:0]   terms,
  output logic [PW-1:0]      sum
);
  for (genvar l = 1; l <= L; l++) begin : g_lvl
    localparam int NO = NP >> l;
    logic [2*NO*PW-1:0] prv;
    logic [NO*PW-1:0]   nxt;
    logic [NO*PW-1:0]   cur;

    if (l == 1) begin : g_first
      assign prv = terms;
    end else begin : g_inner
      assign prv = g_lvl[l-1].cur;
    end

    always_comb begin
      for (int j = 0; j < NO; j++)
        nxt[j*PW +: PW] = prv[(2*j)*PW +: PW] + prv[(2*j+1)*PW +: PW];
    end

    if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)   cur <= '0;
        else if (adv) cur <= nxt;
      end
    end else begin : g_comb
      assign cur = nxt;
    end
  end

  if (L == 0) begin : g_flat
    assign sum = terms;
  end else begin : g_deep
    assign sum = g_lvl[L].cur;
  end
endmodule

// File: rtl/cmul_flow.sv
module cmul_flow #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic adv
);
  logic [DEPTH-1:0] vld;

  assign adv       = !vld[DEPTH-1] || out_ready;
  assign in_ready  = adv;
  assign out_valid = vld[DEPTH-1];

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (!rst_n)   vld <= '0;
      else if (adv) vld <= in_valid;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (!rst_n)   vld <= '0;
      else if (adv) vld <= {vld[DEPTH-2:0], in_valid};
    end
  end

  // R8: reset empties the pipeline
  a_r8_reset_clears: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R6: a stalled output keeps its slot
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
endmodule

// File: rtl/cmul_shiftadd.sv
module cmul_shiftadd #(
  parameter int          IN_W = 8,
  parameter int          S    = 7,
  parameter logic [S:0]  COEF = 8'hE9,
  parameter bit          PIPE = 1'b1,
  localparam int         PW   = IN_W + S + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [PW-1:0]   out_data
);
  localparam int W   = cmul_pkg::popcnt(64'(COEF), S + 1);
  localparam int NT  = cmul_pkg::n_terms(64'(COEF), S);
  localparam int L   = (NT <= 1) ? 0 : $clog2(NT);
  localparam int NP  = 1 << L;
  localparam int LAT = (PIPE ? L : 0) + 1;

  logic              adv;
  logic [NP*PW-1:0]  terms;
  logic [PW-1:0]     tsum;

  cmul_flow #(.DEPTH(LAT)) u_flow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .adv(adv)
  );

  cmul_terms #(.IN_W(IN_W), .S(S), .COEF(COEF), .NP(NP)) u_terms (
    .a(in_data), .bus(terms)
  );

  cmul_tree #(.PW(PW), .L(L), .NP(NP), .PIPE(PIPE)) u_tree (
    .clk(clk), .rst_n(rst_n), .adv(adv), .terms(terms), .sum(tsum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   out_data <= '0;
    else if (adv) out_data <= signed'(tsum);
  end

  // R6: stalled product does not change
  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));

  // R7: input is refused only while a product waits
  a_r7_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  if (W == 0) begin : g_chk_zero
    // R3: zero constant gives zero product
    a_r3_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data == '0);
  end

  if (W == 1) begin : g_chk_shift
    localparam int K = cmul_pkg::term_shift(64'(COEF), S, 0);
    logic signed [PW-1:0] ext;
    assign ext = PW'(in_data);
    // R4: single-bit constant is a pure shift, one cycle late
    a_r4_pure_shift: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_valid && in_ready) |-> out_data == ($past(ext) <<< K));
  end
endmodule

// File: tb/sim_cmul_shiftadd.sv
module sim_cmul_shiftadd;
  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 5;
  localparam logic [7:0] COEFS [NDUT] = '{8'hE9, 8'hFF, 8'h00, 8'h10, 8'hE9};
  localparam bit         PIPES [NDUT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  // R5: expected latency per instance from term counts 5,2,1,1,5
  localparam int         LATS  [NDUT] = '{4, 2, 1, 1, 1};
  localparam int NV = 8;
  localparam logic signed [7:0] VA [NV] = '{8'sd1, -8'sd1, 8'sd127, -8'sd128, 8'sd0, 8'sd5, -8'sd7, 8'sd64};
  localparam int                VE [NV] = '{233, -233, 29591, -29824, 0, 1165, -1631, 14912};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [7:0] in_data = '0;
  logic ir [NDUT];
  logic ov [NDUT];
  logic signed [15:0] od [NDUT];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int seen_lat [NDUT];
  logic signed [15:0] seen_val [NDUT];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmul_shiftadd #(.COEF(COEFS[0]), .PIPE(PIPES[0])) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[0]), .in_data(in_data),
    .out_valid(ov[0]), .out_ready(out_ready), .out_data(od[0])
  );

  for (genvar g = 1; g < NDUT; g++) begin : g_alt
    cmul_shiftadd #(.COEF(COEFS[g]), .PIPE(PIPES[g])) u_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[g]), .in_data(in_data),
      .out_valid(ov[g]), .out_ready(out_ready), .out_data(od[g])
    );
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Push one sample into every instance and record when each result shows.
  task automatic apply(input logic signed [7:0] a);
    @(negedge clk);
    in_data  = a;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < NDUT; k++) begin
      seen_lat[k] = 0;
      seen_val[k] = '0;
    end
    for (int cyc = 1; cyc <= 6; cyc++) begin
      for (int k = 0; k < NDUT; k++)
        if (ov[k] && seen_lat[k] == 0) begin
          seen_lat[k] = cyc;
          seen_val[k] = od[k];
        end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R8: outputs idle during reset
    repeat (3) @(negedge clk);
    for (int k = 0; k < NDUT; k++) chk(ov[k] == 1'b0, "R8", int'(ov[k]), 0);
    rst_n = 1'b1;

    // R1: table of hand-computed products for 8'hE9 (233), plus R5 latency
    for (int v = 0; v < NV; v++) begin
      apply(VA[v]);
      chk(seen_val[0] == 16'(VE[v]), "R1", int'(seen_val[0]), VE[v]);
      chk(seen_lat[0] == 4, "R5", seen_lat[0], 4);
    end

    // Sweep every input through every constant
    for (int a = -128; a < 128; a++) begin
      apply(8'(a));
      for (int k = 0; k < NDUT; k++) begin
        int e;
        e = a * int'(COEFS[k]);
        chk(seen_lat[k] == LATS[k], "R5", seen_lat[k], LATS[k]);
        case (k)
          1: chk(seen_val[k] == 16'(e), "R2", int'(seen_val[k]), e);
          2: chk(seen_val[k] == 16'(e), "R3", int'(seen_val[k]), e);
          3: chk(seen_val[k] == 16'(e), "R4", int'(seen_val[k]), e);
          default: chk(seen_val[k] == 16'(e), "R1", int'(seen_val[k]), e);
        endcase
      end
    end

    // R9: extremes against all-ones
    apply(-8'sd128);
    chk(seen_val[1] == -16'sd32640, "R9", int'(seen_val[1]), -32640);
    apply(8'sd127);
    chk(seen_val[1] == 16'sd32385, "R9", int'(seen_val[1]), 32385);

    // R6 / R7: stall while a sample travels through u0
    @(negedge clk);
    out_ready = 1'b0;
    in_data   = 8'sd3;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    repeat (5) @(negedge clk);
    chk(ov[0] == 1'b1, "R6", int'(ov[0]), 1);
    chk(od[0] == 16'sd699, "R6", int'(od[0]), 699);
    chk(ir[0] == 1'b0, "R7", int'(ir[0]), 0);
    repeat (3) @(negedge clk);
    chk(ov[0] == 1'b1, "R6", int'(ov[0]), 1);
    chk(od[0] == 16'sd699, "R6", int'(od[0]), 699);
    chk(ir[0] == 1'b0, "R7", int'(ir[0]), 0);
    out_ready = 1'b1;
    #1;
    chk(ir[0] == 1'b1, "R7", int'(ir[0]), 1);
    @(negedge clk);
    chk(ov[0] == 1'b0, "R6", int'(ov[0]), 0);

    // R8: reset during flight discards the sample
    in_data  = 8'sd9;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6; cyc++) begin
      chk(ov[0] == 1'b0, "R8", int'(ov[0]), 0);
      @(negedge clk);
    end

    finish_run();
  end
endmodule